// File: doc/BRIEF.md
# Prescaled Free-Running Time Base with Compare Clear

This block is a 16-bit up-counting time base whose live value is handed to a set of capture channels as their common timestamp. A three-bit rate select divides the machine clock by a power of two from 1 to 128 before it reaches the counter. Software can halt counting, zero the counter and its divider in one write, and choose whether a match against a 16-bit compare value restarts the count from zero.

Two sticky events are kept: wrap-around from the all-ones value to zero, and a compare match. Each has its own enable, and each interrupt line is high while its flag and its enable are both set. Every compare-clear step also emits a one-clock start pulse for an analog-to-digital converter. Software reaches the block through a plain register port: a write is taken on any clock where the write strobe is high, and reads are combinational on the address. The port never stalls, so there is no back-pressure. The counter has no stream interface.

Register port map: address 0 is control, address 1 is the compare value, address 2 reads the live count, and address 3 reads as zero. Writes to addresses 2 and 3 are ignored.

Top module: `tbase_timer`

## Requirements
- R1: After reset the count, both interrupt lines, the converter pulse and the control register all read zero.
- R2: The control bits [2:0] hold a rate code s. The counter advances by one exactly once every 2^s clocks, so after k clocks from a soft clear the count is floor(k / 2^s).
- R3: A control write that changes the rate code restarts the divider from zero. The first step at the new rate comes 2^s clocks after the write.
- R4: While control bit 3 (halt) is set, neither the counter nor the divider advances.
- R5: Writing 1 to control bit 5 zeroes the counter and the divider on that clock. This bit always reads back as 0.
- R6: A step from FFFFh to 0000h sets the wrap flag (control bit 6). The flag stays set until software writes 0 to it, and writing 1 to it has no effect. The wrap interrupt is the flag AND the wrap enable (bit 7).
- R7: When control bit 4 (compare mode) is set, a step taken while the count equals the compare value loads 0 instead of count+1. When bit 4 is clear, the count runs through the compare value unchanged.
- R8: Each compare-clear step sets the compare flag (control bit 8). The flag clears only when software writes 0 to it. The compare interrupt is the flag AND the compare enable (bit 9). If a flag event and a clearing write land on the same clock, the event wins.
- R9: The converter start pulse is high for exactly the one clock that follows each compare-clear step. In that clock the count reads 0. A count that sits on the compare value between divided steps does not raise the pulse.
- R10: The control register reads back the rate code, halt, mode, both flags and both enables at the bit positions given above, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| count_o | output | 16 | Live counter value for the capture channels |
| irq_ovf | output | 1 | Wrap interrupt |
| irq_cmp | output | 1 | Compare-match interrupt |
| adc_trig | output | 1 | One-clock converter start pulse |

## Verification
The hardest state to reach is the wrap from FFFFh to 0000h. The count cannot be written, so the only way there is to let the counter run undivided for a full 65,536 clocks after a soft clear. The stimulus arms the wrap enable in that same write. It then checks that the wrap interrupt is still low on the clock that shows FFFFh and high on the next clock, that it stays high, and that it drops only after a write of 0 to the flag. The other hard case is a divided compare match: the count rests on the compare value for two clocks, and the stimulus checks that only the clearing step produces the converter pulse.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned TB_SEL_W = 3;

  localparam int unsigned B_HALT  = TB_SEL_W;
  localparam int unsigned B_MODE  = B_HALT + 1;
  localparam int unsigned B_SCLR  = B_MODE + 1;
  localparam int unsigned B_OFLAG = B_SCLR + 1;
  localparam int unsigned B_OIE   = B_OFLAG + 1;
  localparam int unsigned B_CFLAG = B_OIE + 1;
  localparam int unsigned B_CIE   = B_CFLAG + 1;
  localparam int unsigned CTRL_USED = B_CIE + 1;

  typedef enum logic [1:0] {
    ADR_CTRL  = 2'd0,
    ADR_CMP   = 2'd1,
    ADR_COUNT = 2'd2,
    ADR_NONE  = 2'd3
  } tb_addr_e;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // mask has the low "sel" bits set; a tick fires when they are all ones
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = (sel > SEL_W'(g));
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  logic [CNT_W-1:0] count_q;
  logic             cmp_hit;

  assign cmp_hit = cmp_en && (count_q == cmp_val);
  // compare clear outranks the wrap when the compare value is all ones
  assign cmp_evt = tick && cmp_hit && !clear;
  assign ovf_evt = tick && !cmp_hit && (&count_q) && !clear;
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (tick) begin
      if (cmp_hit) count_q <= '0;
      else         count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [CNT_W-1:0]    reg_wdata,
  output logic [CNT_W-1:0]    reg_rdata,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                ovf_evt,
  input  logic                cmp_evt,
  output logic [TB_SEL_W-1:0] sel_o,
  output logic                halt_o,
  output logic                mode_o,
  output logic [CNT_W-1:0]    cmp_val_o,
  output logic                sclr_o,
  output logic                restart_o,
  output logic                ovf_flag_o,
  output logic                cmp_flag_o,
  output logic                irq_ovf,
  output logic                irq_cmp,
  output logic                adc_trig
);
  logic [TB_SEL_W-1:0] sel_q;
  logic                halt_q, mode_q, oie_q, cie_q;
  logic                oflag_q, cflag_q, trig_q;
  logic [CNT_W-1:0]    cmp_q;
  logic                wr_ctrl, wr_cmp, sel_chg;
  logic [CNT_W-1:0]    ctrl_view;

  assign wr_ctrl = reg_we && (tb_addr_e'(reg_addr) == ADR_CTRL);
  assign wr_cmp  = reg_we && (tb_addr_e'(reg_addr) == ADR_CMP);
  assign sel_chg = wr_ctrl && (reg_wdata[TB_SEL_W-1:0] != sel_q);
  assign sclr_o    = wr_ctrl && reg_wdata[B_SCLR];
  assign restart_o = sclr_o || sel_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      halt_q <= 1'b0;
      mode_q <= 1'b0;
      oie_q  <= 1'b0;
      cie_q  <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q  <= reg_wdata[TB_SEL_W-1:0];
      halt_q <= reg_wdata[B_HALT];
      mode_q <= reg_wdata[B_MODE];
      oie_q  <= reg_wdata[B_OIE];
      cie_q  <= reg_wdata[B_CIE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_q <= '0;
    else if (wr_cmp) cmp_q <= reg_wdata;
  end

  // sticky flags: a written 0 clears, a written 1 keeps; events win
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oflag_q <= 1'b0;
      cflag_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      oflag_q <= ovf_evt || (oflag_q && !(wr_ctrl && !reg_wdata[B_OFLAG]));
      cflag_q <= cmp_evt || (cflag_q && !(wr_ctrl && !reg_wdata[B_CFLAG]));
      trig_q  <= cmp_evt;
    end
  end

  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[TB_SEL_W-1:0]   = sel_q;
    ctrl_view[B_HALT]         = halt_q;
    ctrl_view[B_MODE]         = mode_q;
    ctrl_view[B_OFLAG]        = oflag_q;
    ctrl_view[B_OIE]          = oie_q;
    ctrl_view[B_CFLAG]        = cflag_q;
    ctrl_view[B_CIE]          = cie_q;
  end

  always_comb begin
    unique case (tb_addr_e'(reg_addr))
      ADR_CTRL:  reg_rdata = ctrl_view;
      ADR_CMP:   reg_rdata = cmp_q;
      ADR_COUNT: reg_rdata = count_i;
      default:   reg_rdata = '0;
    endcase
  end

  assign sel_o      = sel_q;
  assign halt_o     = halt_q;
  assign mode_o     = mode_q;
  assign cmp_val_o  = cmp_q;
  assign ovf_flag_o = oflag_q;
  assign cmp_flag_o = cflag_q;
  assign irq_ovf    = oflag_q && oie_q;
  assign irq_cmp    = cflag_q && cie_q;
  assign adc_trig   = trig_q;
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_ovf,
  output logic             irq_cmp,
  output logic             adc_trig
);
  logic [TB_SEL_W-1:0] sel;
  logic                halt_q, mode, sclr_wr, restart, tick;
  logic                ovf_evt, cmp_evt, ovf_flag, cmp_flag;
  logic [CNT_W-1:0]    cmp_val;

  tbase_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .count_i    (count_o),
    .ovf_evt    (ovf_evt),
    .cmp_evt    (cmp_evt),
    .sel_o      (sel),
    .halt_o     (halt_q),
    .mode_o     (mode),
    .cmp_val_o  (cmp_val),
    .sclr_o     (sclr_wr),
    .restart_o  (restart),
    .ovf_flag_o (ovf_flag),
    .cmp_flag_o (cmp_flag),
    .irq_ovf    (irq_ovf),
    .irq_cmp    (irq_cmp),
    .adc_trig   (adc_trig)
  );

  tbase_prescaler #(.SEL_W(TB_SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!halt_q),
    .restart (restart),
    .sel     (sel),
    .tick    (tick)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clear   (sclr_wr),
    .cmp_en  (mode),
    .cmp_val (cmp_val),
    .count   (count_o),
    .ovf_evt (ovf_evt),
    .cmp_evt (cmp_evt)
  );
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_o,
  input logic             adc_trig,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             halt_q,
  input logic             sclr_wr
);
  // R2: the count only ever moves by one step or back to zero
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |->
      (count_o == CNT_W'($past(count_o) + 1'b1) || count_o == '0));

  // R4: a halted counter holds unless software clears it
  assert_halt_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !sclr_wr) |=> $stable(count_o));

  // R5: soft clear leaves a zero count
  assert_sclr_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclr_wr |=> (count_o == '0));

  // R6: the wrap flag rises only on the all-ones to zero step
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count_o == '0 && $past(count_o) == '1));

  // R8: a new compare flag comes with the converter pulse
  assert_cmp_flag_with_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> adc_trig);

  // R9: the converter pulse is seen with the freshly cleared count
  assert_trig_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (count_o == '0));
endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count_o  (count_o),
  .adc_trig (adc_trig),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag),
  .halt_q   (halt_q),
  .sclr_wr  (sclr_wr)
);

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb;
  localparam logic [15:0] HALT  = 16'h0008;
  localparam logic [15:0] MODE  = 16'h0010;
  localparam logic [15:0] SCLR  = 16'h0020;
  localparam logic [15:0] OFLAG = 16'h0040;
  localparam logic [15:0] OIE   = 16'h0080;
  localparam logic [15:0] CFLAG = 16'h0100;
  localparam logic [15:0] CIE   = 16'h0200;
  localparam int K_CNT = 0, K_IOVF = 1, K_ICMP = 2, K_TRIG = 3, K_RD = 4;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata, count_o;
  logic        irq_ovf, irq_cmp, adc_trig;

  tbase_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
    .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .adc_trig(adc_trig)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  int    e;
  item_t it;
  logic [15:0] obs;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      K_CNT:  return count_o;
      K_IOVF: return {15'd0, irq_ovf};
      K_ICMP: return {15'd0, irq_cmp};
      K_TRIG: return {15'd0, adc_trig};
      default: return reg_rdata;
    endcase
  endfunction

  function automatic void push_exp(int due, int kind, logic [15:0] exp, string tag);
    item_t ni;
    int pos;
    ni.due = due; ni.kind = kind; ni.exp = exp; ni.tag = tag;
    pos = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].due > due) begin pos = i; break; end
    end
    sbq.insert(pos, ni);
  endfunction

  // monitor: pops every expectation that falls due and compares it
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      obs = observe(it.kind);
      n_chk++;
      if (it.due < cyc || obs !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 it.tag, it.kind, cyc, obs, it.exp);
      end
    end
    if (cyc > WDOG) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog cycle=%0d actual=running expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    push_exp(cyc + 1, K_CNT,  16'h0, "R1 count");
    push_exp(cyc + 1, K_IOVF, 16'h0, "R1 irq_ovf");
    push_exp(cyc + 1, K_ICMP, 16'h0, "R1 irq_cmp");
    push_exp(cyc + 1, K_TRIG, 16'h0, "R1 adc_trig");
    push_exp(cyc + 1, K_RD,   16'h0, "R1 ctrl");
    idle(2);
    rst_n = 1'b1;
    push_exp(cyc + 5, K_CNT, 16'd5, "R2 undivided after reset");
    idle(6);

    // R2 / R5: divided rates after a soft clear
    for (int s = 1; s <= 7; s += 2) begin
      int d;
      d = 1 << s;
      wr(2'd0, 16'(s) | SCLR);
      e = cyc;
      push_exp(e + 1, K_RD, 16'(s), "R5 clear bit reads 0");
      push_exp(e + d - 1, K_CNT, 16'd0, "R2 before first step");
      push_exp(e + d, K_CNT, 16'd1, "R2 first step");
      push_exp(e + 3 * d, K_CNT, 16'd3, "R2 third step");
      idle(3 * d + 1);
    end

    // R3: rate change restarts the divider
    wr(2'd0, 16'd2 | SCLR);
    idle(2);
    wr(2'd0, 16'd3);
    e = cyc;
    push_exp(e + 7, K_CNT, 16'd0, "R3 no early step");
    push_exp(e + 8, K_CNT, 16'd1, "R3 step after full period");
    idle(9);

    // R4: halt
    wr(2'd0, SCLR);
    idle(9);
    wr(2'd0, HALT);
    e = cyc;
    push_exp(e + 1, K_CNT, 16'd10, "R4 halted value");
    push_exp(e + 2, K_RD, HALT, "R10 ctrl halt bit");
    push_exp(e + 15, K_CNT, 16'd10, "R4 still halted");
    idle(16);
    wr(2'd0, 16'h0);
    e = cyc;
    push_exp(e + 5, K_CNT, 16'd15, "R4 resumed");
    idle(6);

    // R7 / R8 / R9: compare clear undivided
    wr(2'd1, 16'd10);
    wr(2'd0, MODE | CIE | SCLR);
    e = cyc;
    push_exp(e + 10, K_CNT,  16'd10, "R7 reaches compare");
    push_exp(e + 10, K_TRIG, 16'd0,  "R9 no pulse yet");
    push_exp(e + 10, K_ICMP, 16'd0,  "R8 no irq yet");
    push_exp(e + 11, K_CNT,  16'd0,  "R7 cleared on match");
    push_exp(e + 11, K_TRIG, 16'd1,  "R9 pulse");
    push_exp(e + 11, K_ICMP, 16'd1,  "R8 irq");
    push_exp(e + 12, K_CNT,  16'd1,  "R7 counting again");
    push_exp(e + 12, K_TRIG, 16'd0,  "R9 single clock");
    push_exp(e + 12, K_ICMP, 16'd1,  "R8 sticky");
    push_exp(e + 22, K_TRIG, 16'd1,  "R9 second period");
    idle(23);

    // R8: enable gating and clearing
    wr(2'd0, MODE | SCLR);
    e = cyc;
    push_exp(e + 11, K_TRIG, 16'd1, "R9 pulse with irq off");
    push_exp(e + 11, K_ICMP, 16'd0, "R8 irq gated by enable");
    push_exp(e + 13, K_RD, MODE | CFLAG, "R10 ctrl mode and flag");
    idle(14);
    wr(2'd0, MODE | CIE | CFLAG | HALT);
    e = cyc;
    push_exp(e + 1, K_ICMP, 16'd1, "R8 enable exposes kept flag");
    idle(2);
    wr(2'd0, MODE | CIE | HALT);
    e = cyc;
    push_exp(e + 1, K_ICMP, 16'd0, "R8 write 0 clears flag");
    idle(2);

    // R7: mode off runs through the compare value
    wr(2'd0, CIE | SCLR);
    e = cyc;
    push_exp(e + 11, K_CNT,  16'd11, "R7 no clear without mode");
    push_exp(e + 11, K_TRIG, 16'd0,  "R9 no pulse without mode");
    push_exp(e + 12, K_ICMP, 16'd0,  "R8 no flag without mode");
    idle(13);

    // R9: divided compare, count rests on the compare value two clocks
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd1 | MODE | SCLR);
    e = cyc;
    push_exp(e + 6, K_TRIG, 16'd0, "R9 no pulse on arrival");
    push_exp(e + 7, K_CNT,  16'd3, "R7 resting on compare");
    push_exp(e + 7, K_TRIG, 16'd0, "R9 no pulse while resting");
    push_exp(e + 8, K_CNT,  16'd0, "R7 divided clear");
    push_exp(e + 8, K_TRIG, 16'd1, "R9 divided pulse");
    push_exp(e + 9, K_TRIG, 16'd0, "R9 divided single clock");
    idle(10);

    // R6: full wrap
    wr(2'd0, OIE | OFLAG | SCLR);
    e = cyc;
    push_exp(e + 2, K_RD,   OIE,      "R6 writing 1 does not set flag");
    push_exp(e + 2, K_IOVF, 16'd0,    "R6 no irq before wrap");
    push_exp(e + 65535, K_CNT,  16'hFFFF, "R6 all ones");
    push_exp(e + 65535, K_IOVF, 16'd0,    "R6 irq low at all ones");
    push_exp(e + 65536, K_CNT,  16'h0000, "R6 wrapped");
    push_exp(e + 65536, K_IOVF, 16'd1,    "R6 irq on wrap");
    push_exp(e + 65600, K_IOVF, 16'd1,    "R6 flag sticky");
    idle(65601);
    wr(2'd0, OIE);
    e = cyc;
    push_exp(e + 1, K_IOVF, 16'd0, "R6 write 0 clears");
    push_exp(e + 2, K_RD,   OIE,   "R10 ctrl after clear");
    idle(4);

    if (sbq.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule